// File: doc/BRIEF.md
# Serial Shift Register with Parallel Storage Loop

This block pairs a 16-bit shift register with a 16-bit storage register. The two registers form a parallel loop, so either one can be copied into the other in a single clock. A single serial port, modelled here as a separate input, an output and an output enable, either feeds new bits into the low end of the shift register or presents its top bit for reading. The storage register drives a 16-bit parallel status output and can be cleared at any time without a clock.

The two registers have independent clocks: `shift_clk` and `store_clk`. An active-low select gates both clocks and the serial driver. In read mode the bit leaving the top of the shift register is fed back into bit 0. Sixteen read shifts therefore return the shift register to its starting value, so a read does not destroy the data.

Top module: `shiftstore16`

## Requirements
- R1: With `cs_n`=0, `load_sel`=0 and `rd_mode`=0, each rising edge of `shift_clk` moves every shift bit one place toward bit 15, and bit 0 takes `ser_in`. After 16 such edges, the first bit written is in bit 15.
- R2: With `cs_n`=0 and `rd_mode`=1, `ser_oe` is 1 and `ser_out` equals shift bit 15. A read-mode shift (with `load_sel`=0) moves bit 15 into bit 0 and ignores `ser_in`.
- R3: With `cs_n`=0 and `load_sel`=1, a rising edge of `shift_clk` copies all 16 storage bits into the shift register. This applies whatever the value of `rd_mode`.
- R4: With `cs_n`=0 and `clr_n`=1, a rising edge of `store_clk` copies all 16 shift bits into storage. `par_q` always shows the storage register.
- R5: While `clr_n`=0, the storage register is zero and `par_q` reads 0 at once, without any clock edge. A `store_clk` edge during clear leaves storage at zero.
- R6: While `cs_n`=1, edges on `shift_clk` and `store_clk` change neither register, and `ser_oe` is 0.
- R7: With `cs_n`=0 and `rd_mode`=0, `ser_oe` is 0, so the port is free to be driven as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift-register clock, rising edge |
| store_clk | input | 1 | Storage-register clock, rising edge |
| cs_n | input | 1 | Active-low select; gates both clocks and the serial driver |
| clr_n | input | 1 | Active-low asynchronous clear of the storage register |
| rd_mode | input | 1 | 1 = read (drive bit 15), 0 = write (sample `ser_in`) |
| load_sel | input | 1 | 1 = parallel load from storage on `shift_clk`, 0 = shift |
| ser_in | input | 1 | Serial data entering bit 0 in write mode |
| ser_out | output | 1 | Shift bit 15 |
| ser_oe | output | 1 | Enable for the serial port driver |
| par_q | output | 16 | Storage register contents |

## Verification
The hardest case to reach is a store-clock edge that arrives while clear is held low. Here the capture and the clear compete, and the only evidence of a wrong result is the storage value that appears afterwards. The bench drives this case directly and also hits it at random, when a clear overlaps a random store pulse. The bench also shows that sixteen read shifts bring the shift register back to its start. It does this by capturing the register into storage after the read and comparing `par_q` with the pattern it wrote.

// File: rtl/shiftstore16.sv
module shiftstore16 #(
  parameter int W = 16
) (
  input  logic         shift_clk,
  input  logic         store_clk,
  input  logic         cs_n,
  input  logic         clr_n,
  input  logic         rd_mode,
  input  logic         load_sel,
  input  logic         ser_in,
  output logic         ser_out,
  output logic         ser_oe,
  output logic [W-1:0] par_q
);

  logic [W-1:0] sr;
  logic [W-1:0] st;
  logic         en;
  logic         feed;

  assign en   = !cs_n;
  assign feed = rd_mode ? sr[W-1] : ser_in;

  always_ff @(posedge shift_clk) begin
    if (en) begin
      if (load_sel) sr <= st;
      else          sr <= {sr[W-2:0], feed};
    end
  end

  always_ff @(posedge store_clk or negedge clr_n) begin
    if (!clr_n)  st <= '0;
    else if (en) st <= sr;
  end

  assign ser_out = sr[W-1];
  assign ser_oe  = en & rd_mode;
  assign par_q   = st;

  logic armed = 1'b0;
  always_ff @(posedge shift_clk) armed <= 1'b1;

  assert_shift_R1: assert property (@(posedge shift_clk) disable iff (!armed)
    (!cs_n && !load_sel && !rd_mode) |=> (sr[W-1:1] == $past(sr[W-2:0])));

  assert_read_R2: assert property (@(posedge shift_clk) disable iff (!armed)
    (!cs_n && !load_sel && rd_mode) |=> (sr[0] == $past(sr[W-1])));

  assert_load_R3: assert property (@(posedge shift_clk) disable iff (!armed)
    (!cs_n && load_sel) |=> (sr == $past(st)));

  assert_gate_R6: assert property (@(posedge shift_clk) disable iff (!armed)
    cs_n |=> $stable(sr));

  assert_clear_R5: assert property (@(posedge shift_clk)
    !clr_n |-> (par_q == '0));

  always_comb begin
    if (cs_n) assert_hiz_R6: assert (!ser_oe);
  end

endmodule

// File: tb/shiftstore16_bench.sv
module shiftstore16_bench;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic shift_clk = 0, store_clk = 0, cs_n = 1, clr_n = 0;
  logic rd_mode = 0, load_sel = 0, ser_in = 0;
  logic ser_out, ser_oe;
  logic [W-1:0] par_q;

  logic [W-1:0] sr_m, st_m;
  int compared = 0, mismatched = 0;

  shiftstore16 #(.W(W)) u_shiftstore16 (
    .shift_clk(shift_clk), .store_clk(store_clk), .cs_n(cs_n), .clr_n(clr_n),
    .rd_mode(rd_mode), .load_sel(load_sel), .ser_in(ser_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .par_q(par_q)
  );

  function automatic logic [W-1:0] next_sr(logic [W-1:0] s, logic [W-1:0] t,
                                           logic c, logic ld, logic rd, logic d);
    if (c) return s;
    if (ld) return t;
    return {s[W-2:0], rd ? s[W-1] : d};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_ports(string tag);
    check({tag, " R6/R7 ser_oe"}, ser_oe, !cs_n && rd_mode);
    if (ser_oe) check({tag, " R2 ser_out"}, ser_out, sr_m[W-1]);
    check({tag, " R4/R5 par_q"}, par_q, st_m);
  endtask

  task automatic shift_pulse(logic c, logic ld, logic rd, logic d);
    cs_n = c; load_sel = ld; rd_mode = rd; ser_in = d;
    #(CLK_PERIOD/2) shift_clk = 1;
    sr_m = next_sr(sr_m, st_m, c, ld, rd, d);
    #(CLK_PERIOD/2) shift_clk = 0;
  endtask

  task automatic store_pulse(logic c);
    cs_n = c;
    #(CLK_PERIOD/2) store_clk = 1;
    if (!c && clr_n) st_m = sr_m;
    #(CLK_PERIOD/2) store_clk = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    void'($urandom(32'h5eed_673));
    st_m = '0; sr_m = '0;
    #(CLK_PERIOD);
    check("reset R5 par_q", par_q, 0);
    check("reset R6 ser_oe", ser_oe, 0);
    clr_n = 1;

    // R1: serial write of a full word, msb first
    pat = 16'hA5C3;
    for (int i = W-1; i >= 0; i--) begin
      shift_pulse(0, 0, 0, pat[i]);
      check("R7 write oe", ser_oe, 0);
    end
    store_pulse(0);
    check("R1/R4 written word captured", par_q, pat);

    // R3: overwrite shift register, then load back from storage
    for (int i = 0; i < W; i++) shift_pulse(0, 0, 0, 1'b0);
    shift_pulse(0, 1, 1, 1'b1);
    // R2: read back 16 bits, msb first, recirculating
    for (int i = W-1; i >= 0; i--) begin
      rd_mode = 1; cs_n = 0; load_sel = 0;
      #1 check("R2 read bit", ser_out, pat[i]);
      check("R2 read oe", ser_oe, 1);
      shift_pulse(0, 0, 1, ~pat[i]);
    end
    store_pulse(0);
    check("R2/R3 recirculated word", par_q, pat);

    // R6: deselected clocks have no effect
    shift_pulse(1, 0, 0, 1'b1);
    shift_pulse(1, 1, 1, 1'b0);
    check("R6 hiz when deselected", ser_oe, 0);
    store_pulse(1);
    check("R6 storage unchanged", par_q, pat);
    store_pulse(0);
    check("R6 shift reg unchanged", par_q, pat);

    // R5: clear is immediate and beats a store edge
    clr_n = 0; #1;
    st_m = '0;
    check("R5 async clear", par_q, 0);
    store_pulse(0);
    check("R5 clear overrides capture", par_q, 0);
    clr_n = 1;
    store_pulse(0);
    check("R4 capture after clear", par_q, pat);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 10;
      if (op < 6)
        shift_pulse(($urandom % 5) == 0, ($urandom % 6) == 0, $urandom % 2, $urandom % 2);
      else if (op < 9)
        store_pulse(($urandom % 4) == 0);
      else begin
        clr_n = 0; st_m = '0;
        if ($urandom % 2) store_pulse(0);
        #1 clr_n = 1;
      end
      #1 check_ports("random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule